// File: doc/BRIEF.md
# Descriptor Pointer-List Walker

This block is one channel of a memory-to-memory copy engine. A host starts it by writing a single start word. The top three bits of that word choose the command type, and the rest gives the location of a pointer list. The engine then reads the list one entry at a time. Each entry names an array of four-word copy descriptors. The engine runs each descriptor as a word-by-word copy from a source region to a destination region, and it can exchange bytes, halfwords or whole words on the way to the destination.

A list ends at the entry that carries its last-pointer flag. An array ends at the descriptor that carries its last-descriptor flag. Once the last descriptor of the array named by the last entry has been copied, the engine raises a one-cycle done pulse. A start word of the wrong type, or a descriptor that asks for a mode other than single-item, stops the walk and raises a one-cycle error pulse in place of done.

The controller moves through these states:
- IDLE, where a start word is taken.
- PTR_RD and PTR_WAIT, which fetch a list entry.
- DESC_RD and DESC_WAIT, which fetch the four descriptor words.
- DATA_RD and DATA_WAIT, where each beat reads a source word and then writes the swapped word.
- NEXT, which picks the next descriptor, the next list entry or the end of the walk.
- DONE and FAULT, the two completion states.

The transitions are:
- IDLE to PTR_RD on an accepted start word of type 1, and IDLE to FAULT for any other type.
- PTR_RD to PTR_WAIT to DESC_RD.
- DESC_RD to DESC_WAIT and back to DESC_RD three times.
- From the fourth DESC_WAIT to FAULT on a bad mode, to NEXT on a zero length, and otherwise to DATA_RD.
- DATA_RD to DATA_WAIT. From DATA_WAIT back to DATA_RD, or to NEXT after the final beat.
- From NEXT to DESC_RD, to PTR_RD, or to DONE.
- From DONE and from FAULT back to IDLE.

Top module: `dmw_walker`

## Requirements
- R1: After reset the block is idle: `cmd_ready` is 1, and `mem_req`, `done_o` and `err_o` are 0.
- R2: A start word is accepted when `cmd_wr` and `cmd_ready` are both high. If bits 31:29 equal 1, the walk starts at byte address bits[28:0] times 8. Any other type gives `err_o` one cycle after acceptance, with no memory access.
- R3: Each list entry is one word. Bit 31 marks the last entry. Bits 28:0 times 8 give the byte address of a descriptor array. Entries are read from consecutive word addresses.
- R4: A descriptor is four consecutive words: command, source byte address, destination byte address, byte length. Command bit 31 marks the last descriptor of its array. When that bit is clear, the next descriptor follows 16 bytes later. When it is set, the next list entry is fetched.
- R5: A descriptor copies length/4 words, in ascending order, from source to destination. A length of 0 completes the descriptor with no write.
- R6: If command bits 1:0 are non-zero, the walk stops with `err_o` and makes no write for that descriptor.
- R7: When command bit 14 is set, each byte is exchanged with its neighbour inside each halfword, so 0x11223344 is written as 0x22114433.
- R8: When command bit 15 is set, the two halfwords of each word are exchanged. With bits 14 and 15 both set, the byte order of each word is reversed.
- R9: When command bit 16 is set, words are exchanged in pairs at the destination: source word 2k goes to destination word 2k+1 and back. An unpaired final word stays at its own position.
- R10: After the last descriptor of the array named by the last entry, `done_o` is high for exactly one cycle. Each walk gives exactly one completion pulse, and `done_o` and `err_o` are never high together.
- R11: `cmd_ready` is high only in IDLE. A start word written while busy is ignored and has no effect on the walk under way.
- R12: The memory port returns read data on `mem_rdata` in the cycle after a read request. A write is a request with `mem_we` high, and `mem_we` is never high without `mem_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Start-word write strobe |
| cmd_word | input | 32 | Start word: type in 31:29, list address/8 in 28:0 |
| cmd_ready | output | 1 | High while a start word would be accepted |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle error-completion pulse |

## Verification
The bench attacks the two-level termination with a walk of two list entries, one of which names a two-descriptor array. An engine that mixed up the two flags would stop early or run past the list, and this shows up as missing copies or a done pulse in the wrong place. Each swap combination is checked against hand-worked words, including word swap with an odd word count, where an engine that swapped blindly would write past the region or drop the last word. Zero length, a bad mode, a bad type and a start word written while busy are each checked at the ports. The bench counts writes and completion pulses, so a design that wrote anyway or took the second start word is caught.

// File: rtl/dmw_pkg.sv
package dmw_pkg;
    localparam int D_W        = 32;
    localparam int CNT_W      = 30;
    localparam logic [2:0] KIND_PTR_LIST = 3'd1;
    localparam int BIT_LAST   = 31;
    localparam int BIT_BSWAP  = 14;
    localparam int BIT_HSWAP  = 15;
    localparam int BIT_WSWAP  = 16;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PTR_RD,
        ST_PTR_WAIT,
        ST_DESC_RD,
        ST_DESC_WAIT,
        ST_DATA_RD,
        ST_DATA_WAIT,
        ST_NEXT,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    typedef struct packed {
        logic       wswap;
        logic       hswap;
        logic       bswap;
    } swap_ctl_t;
endpackage

// File: rtl/dmw_lane_swap.sv
module dmw_lane_swap
    import dmw_pkg::*;
(
    input  logic [D_W-1:0] din,
    input  logic           bswap,
    input  logic           hswap,
    output logic [D_W-1:0] dout
);
    localparam int HALVES = D_W / 16;

    logic [D_W-1:0] stage1;

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        always_comb begin
            if (bswap) begin
                stage1[16*h +: 16] = {din[16*h +: 8], din[16*h+8 +: 8]};
            end else begin
                stage1[16*h +: 16] = din[16*h +: 16];
            end
        end
    end

    always_comb begin
        if (hswap) begin
            dout = {stage1[15:0], stage1[31:16]};
        end else begin
            dout = stage1;
        end
    end
endmodule

// File: rtl/dmw_dest_index.sv
module dmw_dest_index
    import dmw_pkg::*;
(
    input  logic [CNT_W-1:0] beat,
    input  logic [CNT_W-1:0] nbeats,
    input  logic             wswap,
    output logic [CNT_W-1:0] dst_idx
);
    logic [CNT_W-1:0] partner;

    always_comb begin
        partner = beat ^ CNT_W'(1);
        if (wswap && (partner < nbeats)) begin
            dst_idx = partner;
        end else begin
            dst_idx = beat;
        end
    end
endmodule

// File: rtl/dmw_seq.sv
module dmw_seq
    import dmw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [D_W-1:0]    cmd_word,
    input  logic [D_W-1:0]    mem_rdata,
    input  logic [D_W-1:0]    swapped,
    input  logic [CNT_W-1:0]  dst_idx,
    output logic              cmd_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [D_W-1:0]    mem_wdata,
    output logic              done_o,
    output logic              err_o,
    output logic [CNT_W-1:0]  beat,
    output logic [CNT_W-1:0]  nbeats,
    output swap_ctl_t         swap_ctl
);
    walk_state_e state, state_nx;

    logic [ADDR_W-1:0] ptr_addr;
    logic [ADDR_W-1:0] desc_addr;
    logic [ADDR_W-1:0] d_src;
    logic [ADDR_W-1:0] d_dst;
    logic [1:0]        widx;
    logic              d_last;
    logic [1:0]        d_mode;
    logic              last_ptr;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transition logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_wr) begin
                    if (cmd_word[31:29] == KIND_PTR_LIST) state_nx = ST_PTR_RD;
                    else                                   state_nx = ST_FAULT;
                end
            end
            ST_PTR_RD:   state_nx = ST_PTR_WAIT;
            ST_PTR_WAIT: state_nx = ST_DESC_RD;
            ST_DESC_RD:  state_nx = ST_DESC_WAIT;
            ST_DESC_WAIT: begin
                if (widx != 2'd3)             state_nx = ST_DESC_RD;
                else if (d_mode != 2'd0)      state_nx = ST_FAULT;
                else if (mem_rdata[31:2] == '0) state_nx = ST_NEXT;
                else                          state_nx = ST_DATA_RD;
            end
            ST_DATA_RD:  state_nx = ST_DATA_WAIT;
            ST_DATA_WAIT: begin
                if (beat == nbeats - CNT_W'(1)) state_nx = ST_NEXT;
                else                            state_nx = ST_DATA_RD;
            end
            ST_NEXT: begin
                if (!d_last)       state_nx = ST_DESC_RD;
                else if (last_ptr) state_nx = ST_DONE;
                else               state_nx = ST_PTR_RD;
            end
            ST_DONE:  state_nx = ST_IDLE;
            ST_FAULT: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Walk registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_addr  <= '0;
            desc_addr <= '0;
            d_src     <= '0;
            d_dst     <= '0;
            widx      <= '0;
            d_last    <= 1'b0;
            d_mode    <= '0;
            swap_ctl  <= '0;
            last_ptr  <= 1'b0;
            beat      <= '0;
            nbeats    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cmd_wr) ptr_addr <= ADDR_W'({cmd_word[28:0], 3'b000});
                end
                ST_PTR_WAIT: begin
                    last_ptr  <= mem_rdata[BIT_LAST];
                    desc_addr <= ADDR_W'({mem_rdata[28:0], 3'b000});
                    ptr_addr  <= ptr_addr + ADDR_W'(4);
                    widx      <= '0;
                end
                ST_DESC_WAIT: begin
                    widx <= widx + 2'd1;
                    unique case (widx)
                        2'd0: begin
                            d_last   <= mem_rdata[BIT_LAST];
                            d_mode   <= mem_rdata[1:0];
                            swap_ctl <= '{wswap: mem_rdata[BIT_WSWAP],
                                          hswap: mem_rdata[BIT_HSWAP],
                                          bswap: mem_rdata[BIT_BSWAP]};
                        end
                        2'd1: d_src <= ADDR_W'(mem_rdata);
                        2'd2: d_dst <= ADDR_W'(mem_rdata);
                        2'd3: begin
                            nbeats <= mem_rdata[31:2];
                            beat   <= '0;
                        end
                        default: ;
                    endcase
                end
                ST_DATA_WAIT: beat <= beat + CNT_W'(1);
                ST_NEXT: begin
                    if (!d_last) desc_addr <= desc_addr + ADDR_W'(16);
                    widx <= '0;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        cmd_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        done_o    = 1'b0;
        err_o     = 1'b0;
        unique case (state)
            ST_IDLE: cmd_ready = 1'b1;
            ST_PTR_RD: begin
                mem_req  = 1'b1;
                mem_addr = ptr_addr;
            end
            ST_DESC_RD: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + ADDR_W'({widx, 2'b00});
            end
            ST_DATA_RD: begin
                mem_req  = 1'b1;
                mem_addr = d_src + ADDR_W'({beat, 2'b00});
            end
            ST_DATA_WAIT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = d_dst + ADDR_W'({dst_idx, 2'b00});
                mem_wdata = swapped;
            end
            ST_DONE:  done_o = 1'b1;
            ST_FAULT: err_o  = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/dmw_walker.sv
module dmw_walker
    import dmw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [31:0]       cmd_word,
    output logic              cmd_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              done_o,
    output logic              err_o
);
    logic [D_W-1:0]   swapped;
    logic [CNT_W-1:0] beat;
    logic [CNT_W-1:0] nbeats;
    logic [CNT_W-1:0] dst_idx;
    swap_ctl_t        swap_ctl;

    dmw_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_word  (cmd_word),
        .mem_rdata (mem_rdata),
        .swapped   (swapped),
        .dst_idx   (dst_idx),
        .cmd_ready (cmd_ready),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .done_o    (done_o),
        .err_o     (err_o),
        .beat      (beat),
        .nbeats    (nbeats),
        .swap_ctl  (swap_ctl)
    );

    dmw_lane_swap u_swap (
        .din   (mem_rdata),
        .bswap (swap_ctl.bswap),
        .hswap (swap_ctl.hswap),
        .dout  (swapped)
    );

    dmw_dest_index u_didx (
        .beat    (beat),
        .nbeats  (nbeats),
        .wswap   (swap_ctl.wswap),
        .dst_idx (dst_idx)
    );
endmodule

// File: rtl/dmw_walker_chk.sv
module dmw_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_wr,
    input logic [31:0] cmd_word,
    input logic        cmd_ready,
    input logic        mem_req,
    input logic        mem_we,
    input logic        done_o,
    input logic        err_o
);
    // R10
    no_dual_completion_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    // R10
    done_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && cmd_ready));

    // R11
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_ready) |=> !cmd_ready);

    // R2
    bad_kind_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_ready && cmd_word[31:29] != 3'd1) |=> (err_o && !mem_req));

    // R12
    write_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!mem_req && !done_o && !err_o));
endmodule

bind dmw_walker dmw_walker_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .cmd_word  (cmd_word),
    .cmd_ready (cmd_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .done_o    (done_o),
    .err_o     (err_o)
);

// File: tb/dmw_walker_test.sv
module dmw_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_word = '0;
    logic        cmd_ready, mem_req, mem_we, done_o, err_o;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;

    always #5 clk = ~clk;

    dmw_walker uut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .cmd_ready(cmd_ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done_o(done_o), .err_o(err_o)
    );

    logic [31:0] mem [512];
    int n_done = 0, n_err = 0, n_wr = 0, n_req = 0;
    int checks = 0, fails = 0;
    bit finished = 1'b0;

    always @(posedge clk) begin
        if (mem_req && mem_we) mem[mem_addr[10:2]] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[10:2]];
        if (rst_n) begin
            if (done_o) n_done <= n_done + 1;
            if (err_o) n_err <= n_err + 1;
            if (mem_req && mem_we) n_wr <= n_wr + 1;
            if (mem_req) n_req <= n_req + 1;
        end
    end

    localparam logic [31:0] LASTF = 32'h8000_0000;
    localparam logic [31:0] S0 = 32'h1122_3344;
    localparam logic [31:0] S1 = 32'hAABB_CCDD;

    typedef struct packed {
        logic [2:0]  sw;   // {word, half, byte}
        logic [31:0] e0;
        logic [31:0] e1;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{3'b000, 32'h1122_3344, 32'hAABB_CCDD},
        '{3'b001, 32'h2211_4433, 32'hBBAA_DDCC},
        '{3'b010, 32'h3344_1122, 32'hCCDD_AABB},
        '{3'b011, 32'h4433_2211, 32'hDDCC_BBAA},
        '{3'b100, 32'hAABB_CCDD, 32'h1122_3344},
        '{3'b111, 32'hDDCC_BBAA, 32'h4433_2211}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input int idx, input logic [31:0] v);
        mem[idx] <= v;
    endtask

    task automatic clear_dst();
        for (int i = 384; i < 400; i++) mem[i] <= 32'hDEAD_0000 + 32'(i);
    endtask

    task automatic put_desc(input int w, input logic [31:0] c, input logic [31:0] s,
                            input logic [31:0] d, input logic [31:0] l);
        mem[w] <= c; mem[w+1] <= s; mem[w+2] <= d; mem[w+3] <= l;
    endtask

    task automatic launch(input logic [31:0] w);
        while (!cmd_ready) @(negedge clk);
        cmd_word = w;
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 4000; i++) begin
            if (done_o || err_o) break;
            @(negedge clk);
        end
    endtask

    // start word for a list at byte 0x100
    localparam logic [31:0] START = (32'd1 << 29) | (32'h100 >> 3);

    initial begin
        int d0, e0, w0, r0;
        for (int i = 0; i < 512; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cmd_ready == 1'b1, "R1 ready", 32'(cmd_ready), 32'd1);
        chk(mem_req == 1'b0 && done_o == 1'b0 && err_o == 1'b0, "R1 quiet",
            {29'd0, mem_req, done_o, err_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table: one entry, one descriptor, two words, each swap combination (R5 R7 R8 R9)
        foreach (VECS[k]) begin
            clear_dst();
            poke(64, LASTF | (32'h200 >> 3));
            put_desc(128, LASTF | (32'(VECS[k].sw) << 14), 32'h400, 32'h600, 32'd8);
            poke(256, S0); poke(257, S1);
            @(negedge clk);
            d0 = n_done;
            launch(START);
            wait_end();
            chk(done_o == 1'b1, "R10 done seen", 32'(done_o), 32'd1);
            @(negedge clk);
            chk(done_o == 1'b0 && cmd_ready == 1'b1, "R10 pulse one cycle",
                {30'd0, done_o, cmd_ready}, 32'd1);
            chk(mem[384] == VECS[k].e0, "R7 R8 R9 word0", mem[384], VECS[k].e0);
            chk(mem[385] == VECS[k].e1, "R7 R8 R9 word1", mem[385], VECS[k].e1);
            chk(n_done == d0 + 1, "R10 one done", 32'(n_done - d0), 32'd1);
        end

        // Two entries, first array two descriptors (R3 R4 R5)
        clear_dst();
        poke(68, 32'h240 >> 3);
        poke(69, LASTF | (32'h280 >> 3));
        put_desc(144, 32'h0, 32'h400, 32'h600, 32'd4);
        put_desc(148, LASTF, 32'h404, 32'h608, 32'd8);
        put_desc(160, LASTF, 32'h40C, 32'h620, 32'd4);
        poke(256, 32'hA0A0_0001); poke(257, 32'hB0B0_0002);
        poke(258, 32'hC0C0_0003); poke(259, 32'hD0D0_0004);
        @(negedge clk);
        d0 = n_done; e0 = n_err;
        launch((32'd1 << 29) | (32'h110 >> 3));
        wait_end();
        @(negedge clk);
        chk(mem[384] == 32'hA0A0_0001, "R4 first desc", mem[384], 32'hA0A0_0001);
        chk(mem[386] == 32'hB0B0_0002, "R4 second desc w0", mem[386], 32'hB0B0_0002);
        chk(mem[387] == 32'hC0C0_0003, "R5 second desc w1", mem[387], 32'hC0C0_0003);
        chk(mem[392] == 32'hD0D0_0004, "R3 second entry", mem[392], 32'hD0D0_0004);
        chk(mem[385] == 32'hDEAD_0000 + 32'd385, "R5 gap untouched", mem[385], 32'hDEAD_0000 + 32'd385);
        chk(n_done == d0 + 1 && n_err == e0, "R10 single done multi", 32'(n_done - d0), 32'd1);

        // Zero length (R5)
        clear_dst();
        poke(64, LASTF | (32'h200 >> 3));
        put_desc(128, LASTF, 32'h400, 32'h600, 32'd0);
        @(negedge clk);
        w0 = n_wr; d0 = n_done;
        launch(START);
        wait_end();
        @(negedge clk);
        chk(n_wr == w0, "R5 zero length no write", 32'(n_wr - w0), 32'd0);
        chk(n_done == d0 + 1, "R5 zero length done", 32'(n_done - d0), 32'd1);

        // Word swap with odd count (R9)
        clear_dst();
        put_desc(128, LASTF | (32'd1 << 16), 32'h400, 32'h600, 32'd12);
        poke(256, 32'h0000_0010); poke(257, 32'h0000_0011); poke(258, 32'h0000_0012);
        @(negedge clk);
        launch(START);
        wait_end();
        @(negedge clk);
        chk(mem[384] == 32'h11 && mem[385] == 32'h10, "R9 pair", mem[384], 32'h11);
        chk(mem[386] == 32'h12, "R9 odd tail", mem[386], 32'h12);
        chk(mem[387] == 32'hDEAD_0000 + 32'd387, "R9 no overrun", mem[387], 32'hDEAD_0000 + 32'd387);

        // Bad type (R2)
        r0 = n_req; e0 = n_err;
        launch((32'd2 << 29) | (32'h100 >> 3));
        chk(err_o == 1'b1, "R2 err next cycle", 32'(err_o), 32'd1);
        @(negedge clk);
        chk(n_req == r0 && n_err == e0 + 1, "R2 no memory access", 32'(n_req - r0), 32'd0);

        // Bad mode (R6)
        clear_dst();
        put_desc(128, LASTF | 32'd1, 32'h400, 32'h600, 32'd8);
        @(negedge clk);
        w0 = n_wr; e0 = n_err; d0 = n_done;
        launch(START);
        wait_end();
        chk(err_o == 1'b1, "R6 err", 32'(err_o), 32'd1);
        @(negedge clk);
        chk(n_wr == w0 && n_done == d0, "R6 no write", 32'(n_wr - w0), 32'd0);

        // Write while busy ignored (R11)
        put_desc(128, LASTF, 32'h400, 32'h600, 32'd8);
        @(negedge clk);
        e0 = n_err; d0 = n_done;
        launch(START);
        chk(cmd_ready == 1'b0, "R11 busy", 32'(cmd_ready), 32'd0);
        cmd_word = 32'(2) << 29;
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        wait_end();
        @(negedge clk);
        chk(n_err == e0 && n_done == d0 + 1, "R11 ignored", 32'(n_err - e0), 32'd0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule